// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block models the target side of a three-wire serial EEPROM. A host frames each transaction with chip select. It clocks instruction bits in on the serial clock and reads data back on a tri-stateable output. The serial pins are brought into the system clock domain, and their edges are detected there. This means the serial clock must run several times slower than the system clock. Behind the serial decoder is a 1024-byte array. When the width input is high, the array is addressed as 512 sixteen-bit words. When it is low, it is addressed as 1024 bytes.

Each transaction begins with a start bit and a two-bit opcode, followed by an address. Write-type instructions then carry a data word. Reads return one dummy zero bit and then stream words at consecutive addresses for as long as the clock keeps running. Programming instructions are armed by the serial frame but only begin when chip select falls. They need two conditions: the write-enable latch must be set, and the program-enable input must be high. Programming then occupies a self-timed busy period. During that period the host can raise chip select and poll the output line for status.

Top module: `serial_eeprom_target`

## Requirements
- R1: A transaction begins only at the first serial-clock rising edge that sees chip select and data-in both high. Clock edges with chip select low, or with data-in low while idle, start nothing.
- R2: The two bits after the start bit select the instruction. 10 is read, 01 is write, 11 is erase. For 00, the two most significant address bits choose the instruction: 11 enables programming, 00 disables it, 10 erases the whole array, and 01 writes the whole array. All fields are sent most significant bit first.
- R3: With the width input high, the address is 9 bits and a data word is 16 bits. With it low, the address is 10 bits and a word is 8 bits.
- R4: After the last address bit of a read, the output is driven and shows 0. Each following serial-clock rising edge presents the next data bit, most significant bit first.
- R5: While chip select stays high, a read continues into the next address. The address wraps from the top of the range to 0.
- R6: The output enable is low after reset and whenever chip select is low. It is high only during read output or status reporting.
- R7: While programming is in progress and chip select is high, the output shows 0. Once programming has finished, it shows 1 until chip select falls.
- R8: After reset, write, erase, erase-all and write-all have no effect. The enable instruction allows them, and the disable instruction blocks them again.
- R9: When the program-enable input is low at the moment chip select falls, no programming takes place.
- R10: Erase sets the addressed word to all ones. Erase-all sets every word to all ones.
- R11: Write-all leaves every word holding the supplied pattern. In byte mode, every byte holds the pattern.
- R12: An instruction whose opcode, address or data bits were not all clocked in before chip select fell has no effect.
- R13: Programming lasts at least BUSY_CYCLES system clocks. Serial activity during that period is not decoded as an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| wide_i | input | 1 | Word width select: 1 for 16-bit words, 0 for bytes |
| prog_en_i | input | 1 | Program enable; low blocks all programming |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Output enable for sdo_o |

## Verification
The hardest situation to reach is a complete, well-formed instruction arriving while a programming cycle is still running. Such an instruction must leave no trace. To reach it, the bench ends a write with a chip-select fall and then raises chip select again at once. It clocks in a full write to a neighbouring word, so the serial frame overlaps the busy period and outlasts it. Afterwards, the neighbouring word is read back and compared with its earlier contents. The same chip-select reassertion is used to sample the busy and ready levels. The bench samples once early enough to be certain programming is still running, and once long after it must have ended.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_HOLD,
        ST_BUSY,
        ST_READY
    } eep_state_e;

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    localparam int CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain_q;

    if (STAGES == 1) begin : g_single
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= d_i;
        end
    end else begin : g_multi
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d_i};
        end
    end

    assign q_o = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
    parameter int AW    = 9,
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               we_i,
    input  logic [AW-1:0]      waddr_i,
    input  logic [LANES*8-1:0] wdata_i,
    input  logic [LANES-1:0]   be_i,
    input  logic [AW-1:0]      raddr_i,
    output logic [LANES*8-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i && be_i[l]) cells[waddr_i] <= wdata_i[l*8 +: 8];
        end

        assign rdata_o[l*8 +: 8] = cells[raddr_i];
    end

endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target
    import eep_pkg::*;
#(
    parameter int WORD_AW     = 9,
    parameter int BUSY_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sck_i,
    input  logic sdi_i,
    input  logic wide_i,
    input  logic prog_en_i,
    output logic sdo_o,
    output logic sdo_oe_o
);

    localparam int BYTE_AW   = WORD_AW + 1;
    localparam int HL_WIDE   = 2 + WORD_AW;
    localparam int HL_NARROW = 2 + BYTE_AW;
    localparam int SR_W      = (HL_NARROW > 16) ? HL_NARROW : 16;
    localparam int CNT_W     = $clog2(HL_WIDE + 16 + 1);
    localparam int TMR_W     = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        eep_state_e         st;
        logic               sck_p;
        logic               wide;
        logic [SR_W-1:0]    sr;
        logic [CNT_W-1:0]   cnt;
        logic [1:0]         op;
        logic [BYTE_AW-1:0] addr;
        logic [15:0]        data;
        logic               go;
        logic               full;
        logic               wral;
        logic               wen;
        logic [BYTE_AW-1:0] raddr;
        logic [3:0]         bpos;
        logic [TMR_W-1:0]   tmr;
        logic [WORD_AW:0]   sweep;
        logic               sweep_on;
        logic               sdo;
        logic               oe;
    } regs_t;

    regs_t q, n;

    // ---- pin synchronization ----
    logic [4:0] sy;
    logic cs_s, sck_s, din_s, wide_s, pe_s;

    eep_sync #(.WIDTH(5), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_i, sck_i, sdi_i, wide_i, prog_en_i}),
        .q_o   (sy)
    );
    assign {cs_s, sck_s, din_s, wide_s, pe_s} = sy;

    // ---- array ----
    logic               mem_we;
    logic [WORD_AW-1:0] mem_waddr;
    logic [15:0]        mem_wdata;
    logic [1:0]         mem_be;
    logic [WORD_AW-1:0] mem_raddr;
    logic [15:0]        mem_rdata;

    eep_mem #(.AW(WORD_AW), .LANES(2)) u_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .be_i    (mem_be),
        .raddr_i (mem_raddr),
        .rdata_o (mem_rdata)
    );

    // ---- decode helpers ----
    logic               sck_rise;
    logic [SR_W-1:0]    nsr;
    logic [CNT_W-1:0]   hl, cnt_nx, total;
    logic [1:0]         hop, hcode;
    logic [BYTE_AW-1:0] haddr;
    logic [15:0]        cur_word, pattern;

    always_comb begin
        sck_rise  = sck_s & ~q.sck_p;
        nsr       = {q.sr[SR_W-2:0], din_s};
        cnt_nx    = q.cnt + 1'b1;
        hl        = q.wide ? CNT_W'(HL_WIDE) : CNT_W'(HL_NARROW);
        total     = hl + (q.wide ? CNT_W'(16) : CNT_W'(8));
        hop       = q.wide ? nsr[WORD_AW+1:WORD_AW] : nsr[BYTE_AW+1:BYTE_AW];
        hcode     = q.wide ? nsr[WORD_AW-1:WORD_AW-2] : nsr[BYTE_AW-1:BYTE_AW-2];
        haddr     = q.wide ? {1'b0, nsr[WORD_AW-1:0]} : nsr[BYTE_AW-1:0];
        mem_raddr = q.wide ? q.raddr[WORD_AW-1:0] : q.raddr[BYTE_AW-1:1];
        cur_word  = q.wide ? mem_rdata
                           : {8'h00, (q.raddr[0] ? mem_rdata[15:8] : mem_rdata[7:0])};
        pattern   = q.wide ? q.data : {q.data[7:0], q.data[7:0]};
    end

    // ---- array write port ----
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = q.sweep[WORD_AW-1:0];
        mem_wdata = '1;
        mem_be    = '1;
        if (q.st == ST_BUSY) begin
            if (q.sweep_on) begin
                mem_we = 1'b1;
                if (q.wral && q.sweep[WORD_AW]) mem_wdata = pattern;
            end else if (!q.full && q.tmr == TMR_W'(BUSY_CYCLES)) begin
                mem_we    = 1'b1;
                mem_wdata = (q.op == 2'b11) ? 16'hFFFF : pattern;
                if (q.wide) begin
                    mem_waddr = q.addr[WORD_AW-1:0];
                end else begin
                    mem_waddr = q.addr[BYTE_AW-1:1];
                    mem_be    = q.addr[0] ? 2'b10 : 2'b01;
                end
            end
        end
    end

    // ---- next state ----
    always_comb begin
        n       = q;
        n.sck_p = sck_s;
        unique case (q.st)
            ST_IDLE: begin
                n.oe = 1'b0;
                if (sck_rise && cs_s && din_s) begin
                    n.st   = ST_CMD;
                    n.cnt  = '0;
                    n.wide = wide_s;
                    n.go   = 1'b0;
                    n.full = 1'b0;
                    n.wral = 1'b0;
                end
            end
            ST_CMD: begin
                n.oe = 1'b0;
                if (!cs_s) begin
                    n.st = ST_IDLE;
                end else if (sck_rise) begin
                    n.sr  = nsr;
                    n.cnt = cnt_nx;
                    if (cnt_nx == hl) begin
                        n.op   = hop;
                        n.addr = haddr;
                        unique case (hop)
                            2'b10: begin
                                n.st    = ST_READ;
                                n.raddr = haddr;
                                n.bpos  = q.wide ? 4'd15 : 4'd7;
                                n.sdo   = 1'b0;
                                n.oe    = 1'b1;
                            end
                            2'b11: begin
                                n.st = ST_HOLD;
                                n.go = 1'b1;
                            end
                            2'b01: ;
                            default: begin
                                unique case (hcode)
                                    2'b11: begin n.wen = 1'b1; n.st = ST_HOLD; end
                                    2'b00: begin n.wen = 1'b0; n.st = ST_HOLD; end
                                    2'b10: begin n.full = 1'b1; n.st = ST_HOLD; n.go = 1'b1; end
                                    default: begin n.full = 1'b1; n.wral = 1'b1; end
                                endcase
                            end
                        endcase
                    end else if (cnt_nx == total) begin
                        n.data = q.wide ? nsr[15:0] : {8'h00, nsr[7:0]};
                        n.st   = ST_HOLD;
                        n.go   = 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (!cs_s) begin
                    n.st = ST_IDLE;
                    n.oe = 1'b0;
                end else if (sck_rise) begin
                    n.sdo = cur_word[q.bpos];
                    if (q.bpos == 4'd0) begin
                        n.bpos  = q.wide ? 4'd15 : 4'd7;
                        n.raddr = q.wide ? {1'b0, q.raddr[WORD_AW-1:0] + 1'b1}
                                         : q.raddr + 1'b1;
                    end else begin
                        n.bpos = q.bpos - 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                n.oe = 1'b0;
                if (!cs_s) begin
                    n.go = 1'b0;
                    if (q.go && q.wen && pe_s) begin
                        n.st       = ST_BUSY;
                        n.tmr      = TMR_W'(BUSY_CYCLES);
                        n.sweep    = '0;
                        n.sweep_on = q.full;
                        n.sdo      = 1'b0;
                    end else begin
                        n.st = ST_IDLE;
                    end
                end
            end
            ST_BUSY: begin
                n.oe  = cs_s;
                n.sdo = 1'b0;
                if (q.tmr != '0) n.tmr = q.tmr - 1'b1;
                if (q.sweep_on) begin
                    n.sweep = q.sweep + 1'b1;
                    if (&q.sweep[WORD_AW-1:0] && (q.sweep[WORD_AW] || !q.wral))
                        n.sweep_on = 1'b0;
                end
                if (q.tmr == '0 && !q.sweep_on) begin
                    n.st  = ST_READY;
                    n.sdo = 1'b1;
                end
            end
            default: begin
                n.oe  = cs_s;
                n.sdo = 1'b1;
                if (!cs_s) n.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= n;
    end

    assign sdo_o    = q.sdo;
    assign sdo_oe_o = q.oe;

endmodule

// File: rtl/eep_checker.sv
module eep_checker
    import eep_pkg::*;
#(
    parameter int BUSY_CYCLES = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_s,
    input logic       sck_s,
    input logic       din_s,
    input logic       sdo_o,
    input logic       sdo_oe_o,
    input logic       mem_we,
    input eep_state_e st
);

    logic [31:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              busy_len <= '0;
        else if (st == ST_BUSY)  busy_len <= busy_len + 1'b1;
        else                     busy_len <= '0;
    end

    // R1: a rising serial clock without a start pattern keeps the engine idle
    p_no_false_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && sck_s && !$past(sck_s) && !(cs_s && din_s)) |=> st == ST_IDLE);

    // R4: entering read output drives the dummy zero
    p_dummy_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && $past(st) != ST_READ) |-> (sdo_oe_o && !sdo_o));

    // R6: chip select low releases the output on the next cycle
    p_cs_low_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !sdo_oe_o);

    // R7: busy status reads low, ready status reads high
    p_busy_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && sdo_oe_o) |-> !sdo_o);
    p_ready_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READY && sdo_oe_o) |-> sdo_o);

    // R13: array changes only inside a programming cycle
    p_write_in_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> st == ST_BUSY);

    // R13: programming period lasts at least BUSY_CYCLES
    p_busy_min_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READY && $past(st) == ST_BUSY) |-> busy_len >= BUSY_CYCLES);

endmodule

bind serial_eeprom_target eep_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .sck_s    (sck_s),
    .din_s    (din_s),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o),
    .mem_we   (mem_we),
    .st       (q.st)
);

// File: tb/sim_serial_eeprom_target.sv
`timescale 1ns/1ps
module sim_serial_eeprom_target;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sck = 1'b0, di = 1'b0, org = 1'b1, pe = 1'b1;
    logic sdo, sdo_oe;
    logic cap_do, cap_oe;
    logic [31:0] r;
    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    serial_eeprom_target u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_i      (cs),
        .sck_i     (sck),
        .sdi_i     (di),
        .wide_i    (org),
        .prog_en_i (pe),
        .sdo_o     (sdo),
        .sdo_oe_o  (sdo_oe)
    );

    // {wide, address, write data, expected read}
    localparam int NV = 6;
    localparam logic [42:0] VEC [NV] = '{
        {1'b1, 10'h000, 16'hA55A, 16'hA55A},
        {1'b1, 10'h1FF, 16'h1234, 16'h1234},
        {1'b0, 10'h300, 16'h00C3, 16'h00C3},
        {1'b0, 10'h2C5, 16'h007E, 16'h007E},
        {1'b1, 10'h0AB, 16'hFFFF, 16'hFFFF},
        {1'b1, 10'h0AB, 16'h0001, 16'h0001}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic bit_x(input logic b);
        @(negedge clk) di = b;
        repeat (3) @(negedge clk);
        sck = 1'b1;
        repeat (6) @(negedge clk);
        cap_do = sdo;
        cap_oe = sdo_oe;
        sck = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic shift_out(input logic [15:0] v, input int nb);
        for (int i = nb - 1; i >= 0; i--) bit_x(v[i]);
    endtask

    task automatic sel(input logic v);
        @(negedge clk) cs = v;
        repeat (6) @(negedge clk);
    endtask

    task automatic frame(input logic w, input logic [1:0] opc, input logic [9:0] a,
                         input logic [15:0] d, input int dbits);
        org = w;
        bit_x(1'b1);
        shift_out({14'd0, opc}, 2);
        shift_out({6'd0, a}, w ? 9 : 10);
        if (dbits > 0) shift_out(d, dbits);
    endtask

    task automatic settle();
        repeat (1300) @(negedge clk);
    endtask

    task automatic cmd00(input logic w, input logic [1:0] code, input logic [15:0] d, input int dbits);
        sel(1'b1);
        frame(w, 2'b00, w ? {1'b0, code, 7'd0} : {code, 8'd0}, d, dbits);
        sel(1'b0);
        settle();
    endtask

    task automatic wr(input logic w, input logic [9:0] a, input logic [15:0] d);
        sel(1'b1);
        frame(w, 2'b01, a, d, w ? 16 : 8);
        sel(1'b0);
        settle();
    endtask

    task automatic rd(input logic w, input logic [9:0] a, input int nw, input int lead,
                      output logic [31:0] res);
        sel(1'b1);
        for (int i = 0; i < lead; i++) bit_x(1'b0);
        frame(w, 2'b10, a, 16'd0, 0);
        chk("R4 dummy", {30'd0, cap_oe, cap_do}, 32'd2);
        res = '0;
        for (int k = 0; k < nw * (w ? 16 : 8); k++) begin
            bit_x(1'b0);
            res = {res[30:0], cap_do};
        end
        sel(1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 reset oe", {31'd0, sdo_oe}, 32'd0);

        // R8: enable, write, then reset clears the latch
        cmd00(1'b1, 2'b11, 16'd0, 0);
        wr(1'b1, 10'h050, 16'h1357);
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        wr(1'b1, 10'h050, 16'h2468);
        rd(1'b1, 10'h050, 1, 0, r);
        chk("R8 disabled after reset", r, 32'h1357);

        // vector table: R3 word width and address width
        cmd00(1'b1, 2'b11, 16'd0, 0);
        for (int v = 0; v < NV; v++) begin
            wr(VEC[v][42], VEC[v][41:32], VEC[v][31:16]);
            rd(VEC[v][42], VEC[v][41:32], 1, 0, r);
            chk("R3 write/read vector", r, {16'd0, VEC[v][15:0]});
        end
        wr(1'b0, 10'h100, 16'h005C);
        rd(1'b0, 10'h300, 1, 0, r);
        chk("R3 top byte address bit", r, 32'h00C3);

        // R5 sequential read and wrap
        wr(1'b1, 10'h010, 16'h1111);
        wr(1'b1, 10'h011, 16'h2222);
        rd(1'b1, 10'h010, 2, 0, r);
        chk("R5 sequential", r, 32'h11112222);
        rd(1'b1, 10'h1FF, 2, 0, r);
        chk("R5 wrap", r, 32'h1234A55A);

        // R8/R2: disable instruction blocks writes
        cmd00(1'b1, 2'b00, 16'd0, 0);
        wr(1'b1, 10'h050, 16'h9999);
        rd(1'b1, 10'h050, 1, 0, r);
        chk("R8 R2 disable", r, 32'h1357);

        // R9: program-enable low
        cmd00(1'b1, 2'b11, 16'd0, 0);
        pe = 1'b0;
        wr(1'b1, 10'h050, 16'h4444);
        pe = 1'b1;
        rd(1'b1, 10'h050, 1, 0, r);
        chk("R9 program enable low", r, 32'h1357);

        // R10: single erase
        sel(1'b1);
        frame(1'b1, 2'b11, 10'h010, 16'd0, 0);
        sel(1'b0);
        settle();
        rd(1'b1, 10'h010, 1, 0, r);
        chk("R10 erase word", r, 32'hFFFF);
        rd(1'b1, 10'h011, 1, 0, r);
        chk("R10 neighbour kept", r, 32'h2222);

        // R12: truncated write
        sel(1'b1);
        frame(1'b1, 2'b01, 10'h011, 16'h00AB, 8);
        sel(1'b0);
        settle();
        rd(1'b1, 10'h011, 1, 0, r);
        chk("R12 truncated write", r, 32'h2222);

        // R1: clocks with cs low, then leading zeros before the start bit
        org = 1'b1;
        bit_x(1'b1);
        bit_x(1'b1);
        bit_x(1'b0);
        rd(1'b1, 10'h011, 1, 3, r);
        chk("R1 start detection", r, 32'h2222);

        // R7/R13: status polling and instruction during busy
        wr(1'b1, 10'h021, 16'h0F0F);
        sel(1'b1);
        frame(1'b1, 2'b01, 10'h020, 16'hAAAA, 16);
        sel(1'b0);
        sel(1'b1);
        chk("R7 busy low", {30'd0, sdo_oe, sdo}, 32'd2);
        repeat (30) @(negedge clk);
        chk("R13 still busy", {30'd0, sdo_oe, sdo}, 32'd2);
        frame(1'b1, 2'b01, 10'h021, 16'hBBBB, 16);
        chk("R7 ready high", {30'd0, sdo_oe, sdo}, 32'd3);
        sel(1'b0);
        chk("R6 cs low releases", {31'd0, sdo_oe}, 32'd0);
        settle();
        rd(1'b1, 10'h021, 1, 0, r);
        chk("R13 ignored during busy", r, 32'h0F0F);
        rd(1'b1, 10'h020, 1, 0, r);
        chk("R7 write completed", r, 32'hAAAA);

        // R10: erase all
        cmd00(1'b1, 2'b10, 16'd0, 0);
        rd(1'b1, 10'h000, 1, 0, r);
        chk("R10 erase all low", r, 32'hFFFF);
        rd(1'b1, 10'h1FF, 1, 0, r);
        chk("R10 erase all high", r, 32'hFFFF);
        rd(1'b0, 10'h300, 1, 0, r);
        chk("R10 erase all byte", r, 32'h00FF);

        // R11: write all
        cmd00(1'b0, 2'b01, 16'h003C, 8);
        rd(1'b0, 10'h000, 1, 0, r);
        chk("R11 byte pattern low", r, 32'h003C);
        rd(1'b0, 10'h3FF, 1, 0, r);
        chk("R11 byte pattern high", r, 32'h003C);
        rd(1'b1, 10'h0AB, 1, 0, r);
        chk("R11 byte pattern as word", r, 32'h3C3C);
        cmd00(1'b1, 2'b01, 16'hBEEF, 16);
        rd(1'b1, 10'h123, 1, 0, r);
        chk("R11 word pattern", r, 32'hBEEF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule